// File: doc/BRIEF.md
# Reset Cause and Software Reset Controller

This block is the system reset manager of a small chip. It records which source brought the system out of its last reset. The sources are power-on, the external reset pin, the watchdog, the low-voltage detector, the brown-out detector and the power-management unit. It also records which event woke the device from deep power-down: a pin transition, the wake-up timer or a power-on. Software reads these sticky flags over a simple register interface with single-cycle writes and combinational reads, and clears them with write-one-to-clear.

The block also produces software resets. Two one-shot bits generate a full-chip reset and a CPU-core reset, and each drops by itself after a fixed pulse length. A separate register holds level reset lines for individual peripherals, and each line stays asserted until software writes it back to 0. The analog detectors and the power-down sequencer lie outside the block. They appear as single-cycle request inputs, and every reset is an output line.

Register map, as byte addresses: 0x0 holds the cause and wake flags, 0x4 holds the one-shot reset control, and 0x8 holds the peripheral reset control. Every other address reads as 0 and ignores writes.

Top module: `rstcause_ctrl`

## Requirements
- R1: A one-cycle request on `cause_req` sets its flag in register 0x0, and the flag is visible after the next clock edge. The flag positions are: power-on bit 0 (`cause_req[0]`), pin bit 1, watchdog bit 2, low-voltage bit 3, brown-out bit 4, power-management bit 6 (`cause_req[5]`).
- R2: A cause flag stays set until software writes 1 to its bit at 0x0. Writing 0 leaves it unchanged. If a source asserts in the same cycle as the clearing write, the flag stays set.
- R3: A request on `wake_req[0]` (pin), `wake_req[1]` (timer) or `wake_req[2]` (power-on) sets bit 8, 9 or 10 of 0x0 respectively. These flags are sticky.
- R4: Writing 1 to bit 8 of 0x0 clears all three wake flags at once. Writing 1 only to bits 9 or 10 has no effect. Clearing the wake flags leaves the cause flags unchanged.
- R5: Writing 1 to bit 0 of 0x4 raises `chip_rst_o`, and bit 0 reads back as 1, for exactly 2 cycles. The same write records a power-on cause: bit 0 is set, bits 1 to 6 are cleared, and the wake flags are kept.
- R6: Writing 1 to bit 1 of 0x4 raises `cpu_rst_o`, and bit 1 reads back as 1, for exactly 2 cycles. The cause register is unaffected.
- R7: Writing 1 again to an active one-shot bit restarts its 2-cycle count.
- R8: Register 0x8 drives `periph_rst_o` as level reset lines. The implemented bits are 1, 2, 3, 4, 6, 7, 12, 13, 20, 21 and 29 (mask 0x203030DE). Each line holds until software writes 0 to it, and all other bits stay 0.
- R9: A power-on request clears every other cause flag and sets bit 0 of 0x0. Other sources that assert in the same cycle are still recorded.
- R10: Reserved bits and unmapped addresses read as 0, and writes to them have no effect. Reads never change any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of all registers |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `req_addr` |
| cause_req | input | 6 | Reset source requests: power-on, pin, watchdog, low-voltage, brown-out, power-management |
| wake_req | input | 3 | Deep power-down wake events: pin, timer, power-on |
| chip_rst_o | output | 1 | One-shot full-chip reset |
| cpu_rst_o | output | 1 | One-shot CPU-core and flash-controller reset |
| periph_rst_o | output | 32 | Level peripheral reset lines |

## Verification
The bench targets the interactions between sources and clearing writes:
- A clearing write that lands in the same cycle as a new request. A design that lets the write win would lose a real reset cause.
- The shared wake-flag clear. A design that decodes bits 9 and 10 individually, or clears only bit 8, leaves flags that should be gone, or drops flags that should stay.
- The one-shot pulse width, which is sampled at each of the three cycles after the write, and the restart case. An off-by-one counter, or a counter that ignores rewrites, ends the pulse one or two cycles early or late.
- The power-on event and the software chip reset, which both clear the other cause flags. A design that forgets this shows stale causes.
- Writes to reserved bits and unmapped addresses. A design that stores these shows them on read-back or on `periph_rst_o`.

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl #(
  parameter int          ADDR_W       = 4,
  parameter int          PULSE_CYCLES = 2,
  parameter logic [31:0] PERIPH_MASK  = 32'h203030DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  input  logic [5:0]        cause_req,
  input  logic [2:0]        wake_req,
  output logic              chip_rst_o,
  output logic              cpu_rst_o,
  output logic [31:0]       periph_rst_o
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SHOT   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_PERIPH = ADDR_W'(8);

  logic [5:0]  cause_q;
  logic [2:0]  wake_q;
  logic [31:0] periph_q;
  logic [1:0]  shot_on;

  wire wr        = req_valid & req_write;
  wire wr_cause  = wr && (req_addr == A_CAUSE);
  wire wr_shot   = wr && (req_addr == A_SHOT);
  wire wr_periph = wr && (req_addr == A_PERIPH);

  wire       por_evt   = cause_req[0] | (wr_shot & req_wdata[0]);
  wire [5:0] cause_clr = wr_cause ? {req_wdata[6], req_wdata[4:0]} : 6'b0;
  wire [5:0] cause_set = {cause_req[5:1], por_evt};
  wire       wake_clr  = wr_cause & req_wdata[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q  <= '0;
      wake_q   <= '0;
      periph_q <= '0;
    end else begin
      cause_q <= (por_evt ? 6'b0 : (cause_q & ~cause_clr)) | cause_set;
      wake_q  <= (wake_clr ? 3'b0 : wake_q) | wake_req;
      if (wr_periph) periph_q <= req_wdata & PERIPH_MASK;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_shot
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (wr_shot && req_wdata[g]) cnt_q <= CNT_W'(PULSE_CYCLES);
      else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
    end
    assign shot_on[g] = (cnt_q != '0);
  end

  assign chip_rst_o   = shot_on[0];
  assign cpu_rst_o    = shot_on[1];
  assign periph_rst_o = periph_q;

  always_comb begin
    case (req_addr)
      A_CAUSE:  rd_data = {21'b0, wake_q, 1'b0, cause_q[5], 1'b0, cause_q[4:0]};
      A_SHOT:   rd_data = {30'b0, shot_on};
      A_PERIPH: rd_data = periph_q;
      default:  rd_data = 32'b0;
    endcase
  end
endmodule

// File: rtl/rstcause_ctrl_chk.sv
module rstcause_ctrl_chk #(
  parameter int          ADDR_W       = 4,
  parameter logic [31:0] PERIPH_MASK  = 32'h203030DE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rd_data,
  input logic [5:0]        cause_req,
  input logic [2:0]        wake_req,
  input logic              chip_rst_o,
  input logic              cpu_rst_o,
  input logic [31:0]       periph_rst_o,
  input logic [5:0]        cause_q,
  input logic [2:0]        wake_q
);
  wire wr_c = req_valid && req_write && (req_addr == ADDR_W'(0));
  wire wr_s = req_valid && req_write && (req_addr == ADDR_W'(4));

  p_src_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cause_req[2] |=> cause_q[2]);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q[3] && !(wr_c && req_wdata[3]) && !cause_req[0] && !(wr_s && req_wdata[0])) |=> cause_q[3]);
  p_wake_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req[1] |=> wake_q[1]);
  p_wake_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && req_wdata[8] && wake_req == 3'b0) |=> (wake_q == 3'b0));
  p_chip_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst_o) |=> chip_rst_o);
  p_chip_por_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst_o) |-> cause_q[0]);
  p_cpu_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_o) |=> cpu_rst_o);
  p_periph_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_rst_o & ~PERIPH_MASK) == 32'b0);
  p_por_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_req[0] && cause_req[5:1] == 5'b0) |=> (cause_q == 6'b000001));
  p_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == ADDR_W'(0)) |-> (rd_data[31:11] == 21'b0 && !rd_data[5] && !rd_data[7]));
endmodule

bind rstcause_ctrl rstcause_ctrl_chk #(.ADDR_W(ADDR_W), .PERIPH_MASK(PERIPH_MASK)) u_chk (.*);

// File: tb/test_rstcause_ctrl.sv
module test_rstcause_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic [5:0]  cause_req = '0;
  logic [2:0]  wake_req = '0;
  logic        chip_rst_o, cpu_rst_o;
  logic [31:0] periph_rst_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rstcause_ctrl i_rstcause_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    req_addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(logic [5:0] c, logic [2:0] w);
    cause_req = c; wake_req = w;
    @(negedge clk);
    cause_req = '0; wake_req = '0;
  endtask

  task automatic clean();
    wr(4'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R10 reset cause", d, 0);
    rd(4'h4, d); chk("R10 reset shot", d, 0);
    chk("R8 reset periph", periph_rst_o, 0);
    chk("R5 reset chip", {31'b0, chip_rst_o}, 0);
  endtask

  task automatic t_cause_set_clear();
    logic [31:0] d;
    @(negedge clk);
    pulse(6'b111110, 3'b0);
    rd(4'h0, d); chk("R1 sources set", d, 32'h5E);
    wr(4'h0, 32'h0);
    rd(4'h0, d); chk("R2 write 0 no effect", d, 32'h5E);
    wr(4'h0, 32'h6);
    rd(4'h0, d); chk("R2 w1c partial", d, 32'h58);
    wr(4'h0, 32'h58);
    rd(4'h0, d); chk("R2 w1c rest", d, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    @(negedge clk);
    pulse(6'b000100, 3'b0);
    cause_req = 6'b000100;
    wr(4'h0, 32'h4);
    cause_req = '0;
    rd(4'h0, d); chk("R2 source beats clear", d, 32'h4);
    clean();
    rd(4'h0, d); chk("R2 cleared", d, 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    @(negedge clk);
    pulse(6'b000010, 3'b111);
    rd(4'h0, d); chk("R3 wake set", d, 32'h702);
    wr(4'h0, 32'h600);
    rd(4'h0, d); chk("R4 bits 9,10 no clear", d, 32'h702);
    wr(4'h0, 32'h100);
    rd(4'h0, d); chk("R4 bit 8 clears all wake", d, 32'h002);
    clean();
  endtask

  task automatic t_chip_pulse();
    logic [31:0] d;
    @(negedge clk);
    pulse(6'b000010, 3'b001);
    wr(4'h4, 32'h1);
    rd(4'h4, d); chk("R5 chip bit reads 1", d, 32'h1);
    chk("R5 chip cycle1", {31'b0, chip_rst_o}, 1);
    chk("R6 cpu idle", {31'b0, cpu_rst_o}, 0);
    rd(4'h0, d); chk("R5 por recorded", d, 32'h101);
    @(negedge clk); chk("R5 chip cycle2", {31'b0, chip_rst_o}, 1);
    @(negedge clk); chk("R5 chip dropped", {31'b0, chip_rst_o}, 0);
    rd(4'h4, d); chk("R5 chip bit cleared", d, 0);
    clean();
  endtask

  task automatic t_cpu_pulse();
    logic [31:0] d;
    @(negedge clk);
    pulse(6'b001000, 3'b0);
    wr(4'h4, 32'h2);
    chk("R6 cpu cycle1", {31'b0, cpu_rst_o}, 1);
    chk("R6 chip idle", {31'b0, chip_rst_o}, 0);
    rd(4'h0, d); chk("R6 cause untouched", d, 32'h8);
    @(negedge clk); chk("R6 cpu cycle2", {31'b0, cpu_rst_o}, 1);
    @(negedge clk); chk("R6 cpu dropped", {31'b0, cpu_rst_o}, 0);
    clean();
  endtask

  task automatic t_restart();
    @(negedge clk);
    wr(4'h4, 32'h2);
    wr(4'h4, 32'h2);
    chk("R7 restart c1", {31'b0, cpu_rst_o}, 1);
    @(negedge clk); chk("R7 restart c2", {31'b0, cpu_rst_o}, 1);
    @(negedge clk); chk("R7 restart dropped", {31'b0, cpu_rst_o}, 0);
  endtask

  task automatic t_periph();
    logic [31:0] d;
    @(negedge clk);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R8 masked readback", d, 32'h2030_30DE);
    repeat (5) @(negedge clk);
    chk("R8 level held", periph_rst_o, 32'h2030_30DE);
    wr(4'h8, 32'h2);
    chk("R8 write 0 releases", periph_rst_o, 32'h2);
  endtask

  task automatic t_por();
    logic [31:0] d;
    @(negedge clk);
    pulse(6'b111110, 3'b010);
    pulse(6'b000001, 3'b0);
    rd(4'h0, d); chk("R9 por clears others", d, 32'h201);
    pulse(6'b000101, 3'b0);
    rd(4'h0, d); chk("R9 por with watchdog", d, 32'h205);
    clean();
  endtask

  task automatic t_reserved();
    logic [31:0] d, d2;
    @(negedge clk);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); chk("R10 unmapped reads 0", d, 0);
    chk("R10 unmapped write ignored", periph_rst_o, 32'h2);
    pulse(6'b000010, 3'b0);
    rd(4'h0, d); @(negedge clk); rd(4'h0, d2);
    chk("R10 read no side effect", d2, d);
    chk("R10 reserved bits 0", d & 32'hFFFF_F8A0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cause_set_clear();
    t_same_cycle();
    t_wake();
    t_chip_pulse();
    t_cpu_pulse();
    t_restart();
    t_periph();
    t_por();
    t_reserved();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule